// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block feeds a frame sender from a linked list of transmit descriptors kept in memory. Each descriptor has four 32-bit words: control flags at word 0, buffer address at word 1, status-and-length at word 2, and the address of the next descriptor at word 3. Software hands a descriptor to the engine by setting control bit 31. It then pulses the start-demand input.

For each descriptor it owns, the walker reads the buffer address and the length. It starts the sender and waits for the sender's done pulse. It then writes a completion status back to word 2 and clears the ownership bit in word 0. Last, it reads the next pointer and moves on to that descriptor. The walk stops when it reaches a descriptor whose ownership bit is clear. A later start demand resumes at that same descriptor.

Two sticky status bits record completions and unavailable descriptors. Software clears them by writing 1. Together with per-bit enables they drive one interrupt line. The memory port uses a request/acknowledge handshake for word reads and writes.

Top module: `tdf_fetcher`

## Requirements
- R1: After reset the walker is idle. `active`, `mem_req`, `snd_go`, both status bits and `irq` are 0, and `cur_desc` equals `list_base` with its low 2 bits cleared.
- R2: While `tx_on` is low the walker stays idle and ignores `start_dmd`. `cur_desc` follows `list_base` with its low 2 bits cleared.
- R3: A `start_dmd` pulse while idle and `tx_on` is high starts a walk at `cur_desc`. The walker reads word 0, then word 1 (+4), then word 2 (+8). Each request holds its address until `mem_ack`.
- R4: If word 0 bit 31 is 0, the walker makes no further access, drops `active` and sets status bit 1 (descriptor unavailable). `cur_desc` keeps pointing at that descriptor.
- R5: For an owned descriptor, `snd_go` pulses for one cycle. `snd_buf` is word 1 with its low 2 bits cleared, and `snd_flags` is word 0 bits [2:0].
- R6: `snd_len` is word 2 bits [15:0]. When word 0 bit 0 (pad enable) is set and that length is below MIN_LEN (64), `snd_len` is MIN_LEN instead.
- R7: After `snd_done`, the walker writes word 2 (+8). The value is the original 16-bit length, with bit 19 set and bit 16 equal to word 0 bit 2.
- R8: The walker then writes word 0 back with bit 31 cleared and the other bits unchanged. Next it reads word 3 (+12), loads `cur_desc` with that value's low 2 bits cleared, sets status bit 0 (completion) and reads word 0 of the new descriptor.
- R9: When `tx_on` is low at a clock edge, the walker is idle from that edge on. `mem_req` and `active` are 0, and a pending sender completion is dropped.
- R10: `irq` is high exactly when some status bit and its matching `irq_en` bit are both 1. A 1 in `sts_clr` clears that status bit, and a set in the same cycle wins over a clear.
- R11: A `start_dmd` pulse while a walk is in progress has no effect on the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_on | input | 1 | Transmit enable; low forces idle |
| start_dmd | input | 1 | Start-demand write pulse |
| list_base | input | AW | Descriptor list start address |
| cur_desc | output | AW | Current descriptor address |
| active | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access accepted and complete |
| snd_go | output | 1 | Start the sender (one-cycle pulse) |
| snd_buf | output | AW | Frame buffer address |
| snd_len | output | 16 | Frame length after padding |
| snd_flags | output | 3 | Descriptor flags [2:0] |
| snd_done | input | 1 | Sender finished |
| irq_en | input | 2 | Enable per status bit (0 completion, 1 unavailable) |
| sts_clr | input | 2 | Write-1-to-clear per status bit |
| sts | output | 2 | Sticky status: 0 completion, 1 unavailable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: AW = 32 and MIN_LEN = 64. A 64-word bench memory then holds several chained descriptors. The lengths 20 and 63 fall below the pad limit with padding on. The length 10 is short but has padding off, so it is sent unchanged. The length 200 lies above the limit. With these values the chain covers a walk over two descriptors, a resume after an unavailable stop, a wrap back onto an already returned descriptor, and `tx_on` dropping while the sender runs.

// File: rtl/tdf_pkg.sv
// Package: shared constants and state type for the transmit descriptor walker.
// Assumes 32-bit descriptor words and a 16-bit length field.
package tdf_pkg;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 16;
    localparam int OWN_BIT     = 31;
    localparam int PAD_BIT     = 0;
    localparam int INT_BIT     = 2;
    localparam int ST_DONE_BIT = 19;
    localparam int ST_INT_BIT  = 16;
    localparam int NSTS        = 2;
    localparam int STS_CMPL    = 0;
    localparam int STS_UNAV    = 1;

    localparam logic [1:0] OFS_CTL = 2'd0;
    localparam logic [1:0] OFS_BUF = 2'd1;
    localparam logic [1:0] OFS_LEN = 2'd2;
    localparam logic [1:0] OFS_NXT = 2'd3;

    typedef enum logic [3:0] {
        W_IDLE, W_RD_CTL, W_RD_BUF, W_RD_LEN, W_GO,
        W_WAIT, W_WR_STS, W_WR_CTL, W_RD_NXT
    } wstate_t;
endpackage

// File: rtl/tdf_lenpad.sv
// Length padder: raises a short length to MIN_LEN when padding is requested.
// Assumes MIN_LEN fits in LEN_W bits; MIN_LEN = 0 disables padding entirely.
module tdf_lenpad #(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic [LEN_W-1:0] len_in,
    input  logic             pad_en,
    output logic [LEN_W-1:0] len_out
);
    localparam logic [LEN_W-1:0] MIN_V = LEN_W'(MIN_LEN);

    generate
        if (MIN_LEN > 0) begin : g_pad
            // Select the padded or raw length.
            always_comb len_out = (pad_en && (len_in < MIN_V)) ? MIN_V : len_in;
        end else begin : g_nopad
            logic unused_pad;
            // No padding variant: pass length through.
            always_comb begin
                len_out    = len_in;
                unused_pad = pad_en;
            end
        end
    endgenerate
endmodule

// File: rtl/tdf_stat.sv
// Sticky status bits with write-1-to-clear and an enabled-OR interrupt.
// Assumes set and clear are single-cycle pulses; set wins over clear.
module tdf_stat #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] sts,
    output logic         irq
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            // Hold one status bit until cleared by software.
            always_ff @(posedge clk) begin
                if (!rst_n)      sts[i] <= 1'b0;
                else if (set[i]) sts[i] <= 1'b1;
                else if (clr[i]) sts[i] <= 1'b0;
            end
        end
    endgenerate

    // Combine enabled status into the interrupt line.
    always_comb irq = |(sts & en);
endmodule

// File: rtl/tdf_walker.sv
// Descriptor walker FSM: reads each owned descriptor, starts the sender,
// writes back status and ownership, then follows the next pointer.
// Assumes mem_ack only when mem_req is high, with read data valid alongside.
module tdf_walker
    import tdf_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_on,
    input  logic              start_dmd,
    input  logic [AW-1:0]     list_base,
    output logic [AW-1:0]     cur_desc,
    output logic              active,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              snd_go,
    output logic [AW-1:0]     snd_buf,
    output logic [LEN_W-1:0]  raw_len,
    output logic [WORD_W-1:0] ctl_word,
    input  logic              snd_done,
    output logic              ev_cmpl,
    output logic              ev_unav
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

    wstate_t           state;
    logic [AW-1:0]     cur_q;
    logic [WORD_W-1:0] ctl_q;
    logic [AW-1:0]     buf_q;
    logic [LEN_W-1:0]  len_q;
    logic [1:0]        ofs;

    // Word offset of the access in the current state.
    always_comb begin
        case (state)
            W_RD_BUF:           ofs = OFS_BUF;
            W_RD_LEN, W_WR_STS: ofs = OFS_LEN;
            W_RD_NXT:           ofs = OFS_NXT;
            default:            ofs = OFS_CTL;
        endcase
    end

    // Memory request decode.
    always_comb begin
        mem_req  = (state == W_RD_CTL) || (state == W_RD_BUF) || (state == W_RD_LEN) ||
                   (state == W_WR_STS) || (state == W_WR_CTL) || (state == W_RD_NXT);
        mem_we   = (state == W_WR_STS) || (state == W_WR_CTL);
        mem_addr = cur_q + AW'({ofs, 2'b00});
    end

    // Write-back data: completion status or control word with ownership cleared.
    always_comb begin
        mem_wdata = '0;
        if (state == W_WR_STS) begin
            mem_wdata[LEN_W-1:0]  = len_q;
            mem_wdata[ST_DONE_BIT] = 1'b1;
            mem_wdata[ST_INT_BIT]  = ctl_q[INT_BIT];
        end else if (state == W_WR_CTL) begin
            mem_wdata          = ctl_q;
            mem_wdata[OWN_BIT] = 1'b0;
        end
    end

    // Event pulses aligned with the accepting memory access.
    always_comb begin
        ev_unav = (state == W_RD_CTL) && mem_ack && !mem_rdata[OWN_BIT];
        ev_cmpl = (state == W_RD_NXT) && mem_ack;
    end

    // Walk sequencing and descriptor field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= W_IDLE;
            cur_q <= list_base & ALIGN_MASK;
            ctl_q <= '0;
            buf_q <= '0;
            len_q <= '0;
        end else if (!tx_on) begin
            state <= W_IDLE;
            cur_q <= list_base & ALIGN_MASK;
        end else begin
            case (state)
                W_IDLE:   if (start_dmd) state <= W_RD_CTL;
                W_RD_CTL: if (mem_ack) begin
                    ctl_q <= mem_rdata;
                    state <= mem_rdata[OWN_BIT] ? W_RD_BUF : W_IDLE;
                end
                W_RD_BUF: if (mem_ack) begin
                    buf_q <= mem_rdata[AW-1:0] & ALIGN_MASK;
                    state <= W_RD_LEN;
                end
                W_RD_LEN: if (mem_ack) begin
                    len_q <= mem_rdata[LEN_W-1:0];
                    state <= W_GO;
                end
                W_GO:     state <= W_WAIT;
                W_WAIT:   if (snd_done) state <= W_WR_STS;
                W_WR_STS: if (mem_ack) state <= W_WR_CTL;
                W_WR_CTL: if (mem_ack) state <= W_RD_NXT;
                W_RD_NXT: if (mem_ack) begin
                    cur_q <= mem_rdata[AW-1:0] & ALIGN_MASK;
                    state <= W_RD_CTL;
                end
                default:  state <= W_IDLE;
            endcase
        end
    end

    // Outputs toward the sender and software.
    always_comb begin
        active   = (state != W_IDLE);
        snd_go   = (state == W_GO);
        snd_buf  = buf_q;
        raw_len  = len_q;
        ctl_word = ctl_q;
        cur_desc = cur_q;
    end
endmodule

// File: rtl/tdf_fetcher.sv
// Top: transmit descriptor chain walker with length padding and status/irq.
// Assumes a single-word memory port with request/acknowledge handshake.
module tdf_fetcher
    import tdf_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MIN_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_on,
    input  logic              start_dmd,
    input  logic [AW-1:0]     list_base,
    output logic [AW-1:0]     cur_desc,
    output logic              active,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              snd_go,
    output logic [AW-1:0]     snd_buf,
    output logic [LEN_W-1:0]  snd_len,
    output logic [2:0]        snd_flags,
    input  logic              snd_done,
    input  logic [NSTS-1:0]   irq_en,
    input  logic [NSTS-1:0]   sts_clr,
    output logic [NSTS-1:0]   sts,
    output logic              irq
);
    logic [LEN_W-1:0]  raw_len;
    logic [WORD_W-1:0] ctl_word;
    logic              ev_cmpl, ev_unav;
    logic [NSTS-1:0]   ev_set;

    tdf_walker #(.AW(AW)) u_walk (
        .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .start_dmd(start_dmd),
        .list_base(list_base), .cur_desc(cur_desc), .active(active),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .snd_go(snd_go), .snd_buf(snd_buf), .raw_len(raw_len),
        .ctl_word(ctl_word), .snd_done(snd_done),
        .ev_cmpl(ev_cmpl), .ev_unav(ev_unav)
    );

    tdf_lenpad #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_pad (
        .len_in(raw_len), .pad_en(ctl_word[PAD_BIT]), .len_out(snd_len)
    );

    // Map walker events onto status bit positions.
    always_comb begin
        ev_set           = '0;
        ev_set[STS_CMPL] = ev_cmpl;
        ev_set[STS_UNAV] = ev_unav;
        snd_flags        = ctl_word[2:0];
    end

    tdf_stat #(.N(NSTS)) u_stat (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(sts_clr),
        .en(irq_en), .sts(sts), .irq(irq)
    );
endmodule

// File: rtl/tdf_fetcher_chk.sv
// Checker for tdf_fetcher: protocol and status properties, bound to the top.
module tdf_fetcher_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_on,
    input logic          active,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] cur_desc,
    input logic          snd_go,
    input logic [1:0]    sts,
    input logic [1:0]    irq_en,
    input logic          irq
);
    // R3: a pending request keeps its address until acknowledged.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && tx_on) |=> (mem_req && $stable(mem_addr)));

    // R9: transmit-off forces the port quiet from the next cycle.
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |=> (!mem_req && !active));

    // R4: unavailable status appears together with the walk stopping.
    p_unav_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[1]) |-> !active);

    // R5: the sender start is a single-cycle pulse.
    p_go_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snd_go |=> !snd_go);

    // R8: the current descriptor address stays word aligned.
    p_cur_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_desc[1:0] == 2'b00);

    // R10: a rising interrupt has an enabled status bit behind it.
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> |(sts & irq_en));
endmodule

bind tdf_fetcher tdf_fetcher_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .active(active),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .cur_desc(cur_desc), .snd_go(snd_go), .sts(sts),
    .irq_en(irq_en), .irq(irq)
);

// File: tb/test_tdf_fetcher.sv
`timescale 1ns/1ps
module test_tdf_fetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_on = 1'b0;
    logic        start_dmd = 1'b0;
    logic [31:0] list_base = 32'h43;
    logic [31:0] cur_desc;
    logic        active, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        snd_go, snd_done;
    logic [31:0] snd_buf;
    logic [15:0] snd_len;
    logic [2:0]  snd_flags;
    logic [1:0]  irq_en = 2'b00, sts_clr = 2'b00, sts;
    logic        irq;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] mem [0:63];
    logic [31:0] eq_addr[$], eq_data[$];
    bit          eq_we[$];
    logic [31:0] es_buf[$];
    logic [15:0] es_len[$];
    logic [2:0]  es_flg[$];
    int          done_cnt = 0;

    always #2.5 clk = ~clk;

    tdf_fetcher i_tdf_fetcher (
        .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .start_dmd(start_dmd),
        .list_base(list_base), .cur_desc(cur_desc), .active(active),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .snd_go(snd_go), .snd_buf(snd_buf), .snd_len(snd_len),
        .snd_flags(snd_flags), .snd_done(snd_done), .irq_en(irq_en),
        .sts_clr(sts_clr), .sts(sts), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_op(input bit we, input logic [31:0] a, input logic [31:0] d);
        eq_we.push_back(we); eq_addr.push_back(a); eq_data.push_back(d);
    endtask

    task automatic exp_snd(input logic [31:0] b, input logic [15:0] l, input logic [2:0] f);
        es_buf.push_back(b); es_len.push_back(l); es_flg.push_back(f);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Bench memory: acknowledges one cycle after a request, one word per access.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                mem_rdata <= mem[mem_addr[7:2]];
            end
        end
    end

    // Per-clock model comparison: access stream, sender commands, interrupt line.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(irq == |(sts & irq_en), "R10 irq", {31'd0, irq}, {31'd0, |(sts & irq_en)});
            if (mem_req && mem_ack) begin
                if (eq_addr.size() == 0) begin
                    check(1'b0, "R11 unexpected access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    check(mem_addr == eq_addr[0] && mem_we == eq_we[0], "R3 access addr/dir",
                          {mem_addr[30:0], mem_we}, {eq_addr[0][30:0], eq_we[0]});
                    if (eq_we[0]) check(mem_wdata == eq_data[0], "R7 write data", mem_wdata, eq_data[0]);
                    void'(eq_addr.pop_front()); void'(eq_we.pop_front()); void'(eq_data.pop_front());
                end
            end
            if (snd_go) begin
                if (es_buf.size() == 0) begin
                    check(1'b0, "R5 unexpected send", snd_buf, 32'hFFFF_FFFF);
                end else begin
                    check(snd_buf == es_buf[0], "R5 buffer", snd_buf, es_buf[0]);
                    check(snd_len == es_len[0], "R6 length", {16'd0, snd_len}, {16'd0, es_len[0]});
                    check(snd_flags == es_flg[0], "R5 flags", {29'd0, snd_flags}, {29'd0, es_flg[0]});
                    void'(es_buf.pop_front()); void'(es_len.pop_front()); void'(es_flg.pop_front());
                end
                done_cnt = 3;
            end
            snd_done = 1'b0;
            if (done_cnt > 0) begin
                done_cnt--;
                if (done_cnt == 0) snd_done = 1'b1;
            end
        end else begin
            snd_done = 1'b0;
        end
        if (cyc > 20000) begin
            check(1'b0, "watchdog", cyc, 20000);
            finish_run();
        end
    end

    task automatic demand();
        @(negedge clk) start_dmd = 1'b1;
        @(negedge clk) start_dmd = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!active && eq_addr.size() == 0) break;
        end
        check(!active && eq_addr.size() == 0 && es_buf.size() == 0, tag,
              {31'd0, active}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!active && !mem_req && !snd_go, "R1 idle", {29'd0, active, mem_req, snd_go}, 0);
        check(sts == 2'b00 && !irq, "R1 status", {29'd0, sts, irq}, 0);
        check(cur_desc == 32'h40, "R1 cur_desc", cur_desc, 32'h40);

        // R2: demand ignored while transmit is off; cur follows base
        list_base = 32'h41;
        demand();
        repeat (5) @(negedge clk);
        check(!active && !mem_req, "R2 no walk", {30'd0, active, mem_req}, 0);
        check(cur_desc == 32'h40, "R2 cur tracks base", cur_desc, 32'h40);

        // Chain: 0x40 (pad, inten, len 20) -> 0x60 (crc, len 10) -> 0x80 (unowned)
        mem[16] = 32'h8000_0005; mem[17] = 32'h0000_0203; mem[18] = 32'd20; mem[19] = 32'h61;
        mem[24] = 32'h8000_0002; mem[25] = 32'h0000_0300; mem[26] = 32'd10; mem[27] = 32'h80;
        mem[32] = 32'h0000_0000;
        exp_op(0, 32'h40, 0); exp_op(0, 32'h44, 0); exp_op(0, 32'h48, 0);
        exp_snd(32'h200, 16'd64, 3'b101);
        exp_op(1, 32'h48, 32'h0009_0014); exp_op(1, 32'h40, 32'h0000_0005); exp_op(0, 32'h4C, 0);
        exp_op(0, 32'h60, 0); exp_op(0, 32'h64, 0); exp_op(0, 32'h68, 0);
        exp_snd(32'h300, 16'd10, 3'b010);
        exp_op(1, 32'h68, 32'h0008_000A); exp_op(1, 32'h60, 32'h0000_0002); exp_op(0, 32'h6C, 0);
        exp_op(0, 32'h80, 0);
        tx_on = 1'b1;
        demand();
        wait_idle("R3 chain walk");
        check(sts == 2'b11, "R4 R8 status", {30'd0, sts}, 32'd3);
        check(cur_desc == 32'h80, "R4 cur stays", cur_desc, 32'h80);
        check(mem[16] == 32'h5 && mem[24] == 32'h2, "R8 ownership returned", mem[16], 32'h5);

        // R10: enables and write-1-to-clear
        @(negedge clk) irq_en = 2'b01;
        @(negedge clk) check(irq, "R10 irq on cmpl", {31'd0, irq}, 1);
        sts_clr = 2'b01;
        @(negedge clk) sts_clr = 2'b00;
        check(sts == 2'b10 && !irq, "R10 clear", {30'd0, sts}, 32'd2);
        irq_en = 2'b10;
        @(negedge clk) check(irq, "R10 irq on unav", {31'd0, irq}, 1);
        sts_clr = 2'b11;
        @(negedge clk) sts_clr = 2'b00;
        irq_en = 2'b00;

        // Resume at 0x80 (pad, len 63 -> 64), next wraps to returned 0x40; demand mid-walk (R11)
        mem[32] = 32'h8000_0001; mem[33] = 32'h0000_0400; mem[34] = 32'd63; mem[35] = 32'h40;
        exp_op(0, 32'h80, 0); exp_op(0, 32'h84, 0); exp_op(0, 32'h88, 0);
        exp_snd(32'h400, 16'd64, 3'b001);
        exp_op(1, 32'h88, 32'h0008_003F); exp_op(1, 32'h80, 32'h0000_0001); exp_op(0, 32'h8C, 0);
        exp_op(0, 32'h40, 0);
        demand();
        wait (snd_go);
        demand();
        wait_idle("R11 resume walk");
        check(sts == 2'b11, "R4 wrap unavailable", {30'd0, sts}, 32'd3);
        check(cur_desc == 32'h40, "R8 cur after wrap", cur_desc, 32'h40);
        sts_clr = 2'b11;
        @(negedge clk) sts_clr = 2'b00;

        // R9: transmit-off while the sender runs
        mem[16] = 32'h8000_0000; mem[17] = 32'h0000_0500; mem[18] = 32'd200;
        exp_op(0, 32'h40, 0); exp_op(0, 32'h44, 0); exp_op(0, 32'h48, 0);
        exp_snd(32'h500, 16'd200, 3'b000);
        demand();
        wait (snd_go);
        @(negedge clk) tx_on = 1'b0;
        @(negedge clk);
        check(!active && !mem_req, "R9 forced idle", {30'd0, active, mem_req}, 0);
        repeat (8) @(negedge clk);
        check(!mem_req && sts == 2'b00, "R9 completion dropped", {30'd0, sts}, 0);
        check(mem[18] == 32'd200 && mem[16] == 32'h8000_0000, "R9 no write-back", mem[18], 32'd200);
        check(cur_desc == 32'h40, "R2 cur reloads base", cur_desc, 32'h40);
        finish_run();
    end
endmodule